// File: doc/BRIEF.md
# Digit-Serial GF(2^163) Multiplier

This block multiplies two elements of the binary field GF(2^163) in polynomial basis. Operand A is loaded whole into an internal register while the block is idle. Operand B is never held whole. The block asks for it one W-bit word at a time, starting with the most significant word, and it asks for the next word only after every digit of the current word has been used.

Every multiply cycle takes the top D bits of the current B word. It forms the carry-less product of A with those D bits and XORs that product into the accumulator after shifting the accumulator left by D. The D bits that overflow past bit 162 are folded back through the low terms of the field polynomial, so the accumulator holds a reduced element after every cycle.

A stall input freezes the whole sequence for as long as it is high. This lets the surrounding memory arbiter take the shared memory away from the multiplier at any time. When the last digit has been processed, a one-cycle done flag is raised and the product stays on the result port until the next start.

Top module: `gf2m_dsmul`

## Requirements
- R1: Synchronous active-low reset leaves done low, b_req low and result equal to zero.
- R2: When done is high, result equals A·B reduced modulo f(x) = x^163 + x^7 + x^6 + x^3 + 1. B bit i is bit (i mod 16) of the word with index i/16.
- R3: Words of B are requested by holding b_req high with b_index naming the word. The index runs from 10 down to 0. A word is taken on a clock edge where b_req and b_valid are both high, and b_req is low in the cycle that follows.
- R4: With stall low and b_valid always high, done rises 99 cycles after the edge that takes start (11 words × (1 fetch + 8 digit cycles) for D = 2).
- R5: While stall is high, b_req is low and neither the accumulator, operand A nor the sequence position changes.
- R6: Bits 3 to 15 of word 10 lie above bit 162 and have no effect on the result.
- R7: start and a_load are ignored while a multiplication is in progress.
- R8: done is high for exactly one cycle per multiplication, and result stays unchanged from then until the next accepted start.
- R9: An accepted start clears the accumulator, so result reads zero in the following cycle.
- R10: b_valid has no effect in a cycle where b_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication (taken only when idle and not stalled) |
| a_load | input | 1 | Load a_in into operand A (taken only when idle and not stalled) |
| a_in | input | 163 | Operand A value |
| stall | input | 1 | Freeze all progress for this cycle |
| b_req | output | 1 | Request for the word of B named by b_index |
| b_index | output | 4 | Index of the requested B word (10 = most significant) |
| b_valid | input | 1 | b_word carries the requested word |
| b_word | input | 16 | Word of operand B |
| done | output | 1 | One-cycle pulse when the product is ready |
| result | output | 163 | Accumulator contents, the product once done has been seen |

## Verification
The assertions take three things for granted about the inputs. The word offered on b_word whenever b_valid is high belongs to the index currently shown on b_index. Memory contents do not change during a multiplication. Stall may arrive in any cycle, including the fetch cycle and the cycle that follows start.

The stimulus respects these assumptions by deriving b_word from b_index through a fixed word array that is only rewritten while the block is idle. It then randomizes stall, b_valid, and stray start and a_load pulses on every cycle of a run. A behavioural model in the bench follows the fetch and digit sequence and checks request, index, done and result on every cycle. Each product is also compared with a bit-serial reference multiply.

// File: rtl/gfm_pkg.sv
// Shared definitions for the digit-serial GF(2^m) multiplier.
// Assumes the reduction polynomial's low part has degree below TAP_W.
package gfm_pkg;

    // Controller sequence states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MUL   = 2'd2
    } mul_state_t;

    // Width of the low-term tap vector of the reduction polynomial
    localparam int TAP_W = 8;

    // Low terms of x^163 + x^7 + x^6 + x^3 + 1 (bits 7, 6, 3, 0)
    localparam logic [TAP_W-1:0] RED_TAPS_163 = 8'b1100_1001;

endpackage

// File: rtl/gfm_step.sv
// One digit step of the MSB-first multiplier: (work << D) ^ (A * digit), reduced.
// Purely combinational. Assumes the highest tap degree plus D-1 stays below N,
// so a single fold of the D overflow bits is enough for full reduction.
module gfm_step
    import gfm_pkg::*;
#(
    parameter int               N    = 163,
    parameter int               D    = 2,
    parameter logic [TAP_W-1:0] TAPS = RED_TAPS_163
) (
    input  logic [N-1:0] work_i,
    input  logic [N-1:0] a_i,
    input  logic [D-1:0] dig_i,
    output logic [N-1:0] work_o
);

    localparam int SW = N + D;

    logic [SW-1:0] pp [D];
    logic [SW-1:0] acc;
    logic [D-1:0]  high;
    logic [N-1:0]  fold;

    // One shifted copy of A per digit bit, gated by that bit
    for (genvar j = 0; j < D; j++) begin : g_pp
        assign pp[j] = dig_i[j] ? (SW'(a_i) << j) : '0;
    end

    // Shift the accumulator by one digit and XOR in all partial products
    always_comb begin
        acc = {work_i, {D{1'b0}}};
        for (int j = 0; j < D; j++) begin
            acc = acc ^ pp[j];
        end
    end

    assign high = acc[SW-1:N];

    // Fold the overflow bits back through the polynomial's low terms
    always_comb begin
        fold = '0;
        for (int k = 0; k < TAP_W; k++) begin
            if (TAPS[k]) begin
                fold = fold ^ (N'(high) << k);
            end
        end
    end

    assign work_o = acc[N-1:0] ^ fold;

endmodule

// File: rtl/gfm_bbuf.sv
// Holds the current W-bit word of operand B and presents its top D bits.
// Masks the padding bits of the most significant word on load; shifts
// left by D on each digit step. Assumes D divides W.
module gfm_bbuf #(
    parameter int W         = 16,
    parameter int D         = 2,
    parameter int VALID_TOP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         top_word,
    input  logic [W-1:0] word_i,
    input  logic         shift,
    output logic [D-1:0] dig_o
);

    localparam logic [W-1:0] TOP_MASK =
        (VALID_TOP >= W) ? {W{1'b1}} : W'((64'd1 << VALID_TOP) - 64'd1);

    logic [W-1:0] opb_q;
    logic [W-1:0] masked;

    // Clear the bits above the field size when the top word arrives
    assign masked = top_word ? (word_i & TOP_MASK) : word_i;

    // Word register: load a fresh word or move to the next digit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opb_q <= '0;
        end else if (load) begin
            opb_q <= masked;
        end else if (shift) begin
            opb_q <= opb_q << D;
        end
    end

    assign dig_o = opb_q[W-1 -: D];

endmodule

// File: rtl/gfm_ctrl.sv
// Sequencer: fetches B words from the top index down, runs W/D digit steps
// per word, pulses done after the last step. Stall freezes every register
// except the done pulse, which always clears after one cycle.
module gfm_ctrl
    import gfm_pkg::*;
#(
    parameter  int NW  = 11,
    parameter  int DPW = 8,
    localparam int IW  = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stall,
    input  logic          b_valid,
    output logic          b_req,
    output logic [IW-1:0] b_index,
    output logic          load_b,
    output logic          top_word,
    output logic          step,
    output logic          clear,
    output logic          busy,
    output logic          done
);

    localparam int DW = (DPW > 1) ? $clog2(DPW) : 1;

    mul_state_t    state_q;
    logic [IW-1:0] word_q;
    logic [DW-1:0] dig_q;
    logic          done_q;
    logic          last_step;

    // Decode of the current state into datapath strobes
    always_comb begin
        busy      = (state_q != ST_IDLE);
        b_req     = (state_q == ST_FETCH) && !stall;
        load_b    = b_req && b_valid;
        step      = (state_q == ST_MUL) && !stall;
        clear     = (state_q == ST_IDLE) && start && !stall;
        last_step = step && (dig_q == '0) && (word_q == '0);
        top_word  = (word_q == IW'(NW - 1));
    end

    // State, word and digit counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            dig_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_step;
            case (state_q)
                ST_IDLE: begin
                    if (clear) begin
                        state_q <= ST_FETCH;
                        word_q  <= IW'(NW - 1);
                    end
                end
                ST_FETCH: begin
                    if (load_b) begin
                        state_q <= ST_MUL;
                        dig_q   <= DW'(DPW - 1);
                    end
                end
                ST_MUL: begin
                    if (step) begin
                        if (dig_q == '0) begin
                            if (word_q == '0) begin
                                state_q <= ST_IDLE;
                            end else begin
                                word_q  <= word_q - 1'b1;
                                state_q <= ST_FETCH;
                            end
                        end else begin
                            dig_q <= dig_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign b_index = word_q;
    assign done    = done_q;

    // R8: the completion flag never lasts two cycles
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a taken word is followed by at least one cycle without a request
    a_r3_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && b_valid) |=> !b_req);

    // R3: the top word is always the first one requested after a start
    a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !stall) |=> (b_index == IW'(NW - 1)));

endmodule

// File: rtl/gf2m_dsmul.sv
// Digit-serial GF(2^N) multiplier, B consumed MSB digit first, reduced each cycle.
// Assumes b_word matches b_index whenever b_valid is high and that the B words
// stay constant for the duration of a multiplication.
module gf2m_dsmul
    import gfm_pkg::*;
#(
    parameter  int               N    = 163,
    parameter  int               W    = 16,
    parameter  int               D    = 2,
    parameter  logic [TAP_W-1:0] TAPS = RED_TAPS_163,
    localparam int               NW   = (N + W - 1) / W,
    localparam int               IW   = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          a_load,
    input  logic [N-1:0]  a_in,
    input  logic          stall,
    output logic          b_req,
    output logic [IW-1:0] b_index,
    input  logic          b_valid,
    input  logic [W-1:0]  b_word,
    output logic          done,
    output logic [N-1:0]  result
);

    localparam int DPW       = W / D;
    localparam int VALID_TOP = N - (NW - 1) * W;

    logic [N-1:0] a_q;
    logic [N-1:0] work_q;
    logic [N-1:0] work_nx;
    logic [D-1:0] digit;
    logic         load_b;
    logic         top_word;
    logic         step;
    logic         clear;
    logic         busy;

    gfm_ctrl #(
        .NW  (NW),
        .DPW (DPW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .stall    (stall),
        .b_valid  (b_valid),
        .b_req    (b_req),
        .b_index  (b_index),
        .load_b   (load_b),
        .top_word (top_word),
        .step     (step),
        .clear    (clear),
        .busy     (busy),
        .done     (done)
    );

    gfm_bbuf #(
        .W         (W),
        .D         (D),
        .VALID_TOP (VALID_TOP)
    ) u_bbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_b),
        .top_word (top_word),
        .word_i   (b_word),
        .shift    (step),
        .dig_o    (digit)
    );

    gfm_step #(
        .N    (N),
        .D    (D),
        .TAPS (TAPS)
    ) u_step (
        .work_i (work_q),
        .a_i    (a_q),
        .dig_i  (digit),
        .work_o (work_nx)
    );

    // Operand A register, writable only while idle and not stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else if (a_load && !busy && !stall) begin
            a_q <= a_in;
        end
    end

    // Accumulator: cleared by start, advanced one digit per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (clear) begin
            work_q <= '0;
        end else if (step) begin
            work_q <= work_nx;
        end
    end

    assign result = work_q;

    // R5: a stalled cycle leaves accumulator and operand A untouched
    a_r5_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(work_q) && $stable(a_q)));

    // R9: an accepted start leaves a zero accumulator behind
    a_r9_clear_work: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !stall) |=> (work_q == '0));

    // R8: with no start, an idle block keeps its product
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(work_q));

    // R7: operand A cannot change once a multiplication has begun
    a_r7_a_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(a_q));

endmodule

// File: tb/gf2m_dsmul_bench.sv
// Self-checking bench: behavioural cycle model plus a bit-serial reference multiply.
module gf2m_dsmul_bench;

    localparam int N   = 163;
    localparam int W   = 16;
    localparam int D   = 2;
    localparam int NW  = (N + W - 1) / W;
    localparam int DPW = W / D;
    localparam int IW  = $clog2(NW);
    localparam int PADW = NW * W - N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          a_load = 1'b0;
    logic [N-1:0]  a_in = '0;
    logic          stall = 1'b0;
    logic          b_valid = 1'b0;
    logic [W-1:0]  b_word;
    logic          b_req;
    logic [IW-1:0] b_index;
    logic          done;
    logic [N-1:0]  result;

    logic [W-1:0]  bmem [NW];

    int compared = 0;
    int mismatched = 0;

    // 50 MHz clock: 20 ns period with 1 ns time units
    always #10 clk = ~clk;

    assign b_word = bmem[b_index];

    gf2m_dsmul u_gf2m_dsmul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .a_load  (a_load),
        .a_in    (a_in),
        .stall   (stall),
        .b_req   (b_req),
        .b_index (b_index),
        .b_valid (b_valid),
        .b_word  (b_word),
        .done    (done),
        .result  (result)
    );

    // Bit-serial reference: Horner over B, one bit at a time
    function automatic logic [N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            r = r << 1;
            if (r[N]) begin
                r[N] = 1'b0;
                r[7] = ~r[7];
                r[6] = ~r[6];
                r[3] = ~r[3];
                r[0] = ~r[0];
            end
            if (b[i]) r[N-1:0] = r[N-1:0] ^ a;
        end
        return r[N-1:0];
    endfunction

    // B as the field element the words describe (bits above N-1 dropped)
    function automatic logic [N-1:0] b_from_mem();
        logic [NW*W-1:0] f;
        for (int i = 0; i < NW; i++) f[i*W +: W] = bmem[i];
        return f[N-1:0];
    endfunction

    function automatic logic [N-1:0] rand_elem();
        logic [191:0] t;
        for (int i = 0; i < 6; i++) t[i*32 +: 32] = $urandom;
        return t[N-1:0];
    endfunction

    task automatic fill_b(input logic [N-1:0] bv, input logic [PADW-1:0] pad);
        logic [NW*W-1:0] f;
        f = {pad, bv};
        for (int i = 0; i < NW; i++) bmem[i] = f[i*W +: W];
    endtask

    // ---------------- behavioural model ----------------
    int           ms = 0;    // 0 idle, 1 waiting for word, 2 digits
    int           mw = 0;
    int           md = 0;
    bit           mdone = 1'b0;
    logic [N-1:0] ma = '0;
    logic [N-1:0] mres = '0;
    bit           mres_valid = 1'b0;

    always @(posedge clk) begin
        mdone = 1'b0;
        if (!rst_n) begin
            ms = 0; mw = 0; md = 0; ma = '0; mres = '0; mres_valid = 1'b1;
        end else if (!stall) begin
            if (ms == 0) begin
                if (a_load) ma = a_in;
                if (start) begin
                    ms = 1; mw = NW - 1; mres = '0; mres_valid = 1'b1;
                end
            end else if (ms == 1) begin
                mres_valid = 1'b0;
                if (b_valid) begin
                    ms = 2; md = DPW - 1;
                end
            end else begin
                mres_valid = 1'b0;
                if (md == 0) begin
                    if (mw == 0) begin
                        ms = 0; mdone = 1'b1;
                        mres = ref_mul(ma, b_from_mem());
                        mres_valid = 1'b1;
                    end else begin
                        mw = mw - 1; ms = 1;
                    end
                end else begin
                    md = md - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance to the falling edge and compare every output with the model
    task automatic tick();
        @(negedge clk);
        chk("R3 request line", N'(b_req), N'(ms == 1 && !stall));
        if (b_req) chk("R3 word index", N'(b_index), N'(mw));
        chk("R8 done pulse", N'(done), N'(mdone));
        if (mres_valid) chk("R2 result", result, mres);
    endtask

    // One multiplication; returns the number of falling edges until done
    task automatic run_mul(input logic [N-1:0] a, input int stall_pct,
                           input int valid_pct, input bit junk, output int cycles);
        a_load = 1'b1; a_in = a; stall = 1'b0; start = 1'b0;
        tick();
        a_load = 1'b0; start = 1'b1;
        b_valid = ($urandom_range(99) < valid_pct);
        cycles = 0;
        while (cycles < 3000) begin
            tick();
            cycles++;
            start = 1'b0; a_load = 1'b0;
            if (cycles == 1) chk("R9 accumulator cleared", result, '0);
            if (done) break;
            stall   = ($urandom_range(99) < stall_pct);
            b_valid = ($urandom_range(99) < valid_pct);
            if (junk && $urandom_range(99) < 10) begin
                start = 1'b1; a_load = 1'b1; a_in = rand_elem();
            end
        end
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL R4 watchdog: actual no done expected done");
        end
        stall = 1'b0; b_valid = 1'b0; start = 1'b0; a_load = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int cyc;
        logic [N-1:0] a, b, hold;
        for (int i = 0; i < NW; i++) bmem[i] = '0;

        // R1: reset state
        repeat (3) tick();
        chk("R1 done low", N'(done), '0);
        chk("R1 request low", N'(b_req), '0);
        chk("R1 result zero", result, '0);
        rst_n = 1'b1;
        tick();

        // R2: A = 1, B = x^162
        b = '0; b[N-1] = 1'b1;
        fill_b(b, '0);
        run_mul(N'(1), 0, 100, 1'b0, cyc);
        chk("R2 identity times top bit", result, b);

        // R2: x * x^162 = x^163 reduces to x^7+x^6+x^3+1
        run_mul(N'(2), 0, 100, 1'b0, cyc);
        chk("R2 single fold", result, N'(8'hC9));

        // R4: all ones, zero-wait memory, no stall
        a = '1; b = '1;
        fill_b(b, '0);
        run_mul(a, 0, 100, 1'b0, cyc);
        chk("R4 latency", N'(cyc), N'(NW * (DPW + 1) + 1));
        chk("R2 all ones", result, ref_mul(a, b));

        // R2: zero operand
        fill_b('0, '0);
        run_mul(rand_elem(), 0, 100, 1'b0, cyc);
        chk("R2 zero B", result, '0);

        // R5 R7 R10: random operands under stalls, sparse valid, stray start/a_load
        for (int n = 0; n < 6; n++) begin
            a = rand_elem(); b = rand_elem();
            fill_b(b, '0);
            run_mul(a, 30, 50, 1'b1, cyc);
            chk("R7 R10 R5 product under disturbance", result, ref_mul(a, b));
        end

        // R6: garbage above bit 162 in the top word
        a = rand_elem(); b = rand_elem();
        fill_b(b, '1);
        run_mul(a, 20, 70, 1'b0, cyc);
        chk("R6 padding ignored", result, ref_mul(a, b));

        // R8: result held while idle, with stalls and a_load but no start
        hold = result;
        for (int n = 0; n < 8; n++) begin
            stall = n[0]; a_load = 1'b1; a_in = rand_elem();
            tick();
        end
        a_load = 1'b0; stall = 1'b0;
        tick();
        chk("R8 result held", result, hold);

        // R5: start offered only under stall is not taken
        stall = 1'b1; start = 1'b1;
        tick(); tick();
        start = 1'b0; stall = 1'b0;
        tick();
        chk("R5 stalled start ignored", N'(b_req), '0);
        chk("R5 stalled start keeps result", result, hold);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule